// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block steps an external integrating analog front end through an endless series of conversion cycles. Each cycle is auto zero, then integrate, then deintegrate, then integrator zero, and then back to auto zero. The block drives a two-bit phase code to the front end and watches the front end's comparator output. During deintegration it counts system ticks until the comparator falls from high to low. That count is the magnitude of the result. The sign of the result is taken from the comparator at the close of the integrate phase.

All sequencing runs on a system tick that fires once every four input clocks. The integrate length is picked by a three-bit select. The select is read when integration begins and scales a base tick count by a fixed multiplier, which gives lengths from about 16.7 ms to 300 ms. Code 5 gives the recommended 100 ms.

When a result is ready, the block raises a ready flag for a separate serial output block. It stays in auto zero until that block reports that the transfer is done, or until a timeout expires. A power-down input forces the sequencer into an idle auto zero state for as long as it is held.

Top module: `dslope_seq`

## Requirements
- R1: The phase output follows the fixed order auto zero (2'b00), integrate (2'b01), deintegrate (2'b10), integrator zero (2'b11), then back to auto zero. No phase is skipped and none repeats out of order.
- R2: State advances only on a system tick, which fires once every 4 clocks. Every phase therefore lasts a multiple of 4 clocks. An auto zero with no result pending lasts AZ_TICKS ticks.
- R3: Integrate lasts INT_BASE times a multiplier, in ticks. The multiplier is taken from `int_sel` as it stands on entry to integrate: 0→10, 1→12, 2→20, 3→30, 4→40, 5→60, 6→120, 7→180. A change of `int_sel` during integrate has no effect on its length.
- R4: `sign` is the value of `cmp_in` at the last tick of integrate, so 1 means positive and 0 means negative.
- R5: Deintegrate ends at the first tick where `cmp_in` is low and was high at the previous tick. `mag` then holds the number of ticks counted before that tick, so a fall that is seen K ticks after entry gives `mag` = K. Deintegrate lasts K+1 ticks.
- R6: If no falling edge comes, `mag` saturates at 2^MAG_W−1. The next tick moves the block to integrator zero, so deintegrate lasts 2^MAG_W ticks.
- R7: Integrator zero lasts IZ_TICKS ticks. On return to auto zero, `rdy` is 1.
- R8: `rdy` is only ever 1 in auto zero, and integrate never starts while `rdy` is 1. A one-clock `xfer_done` pulse clears `rdy` at the next clock edge. Auto zero then lasts AZ_TICKS ticks in total.
- R9: Without `xfer_done`, `rdy` falls after XFER_TICKS ticks of auto zero, and integrate starts on the following tick.
- R10: While `pwr_dn` is 1, the phase is auto zero and `rdy` is 0 from the next clock edge onward. The cycle resumes once `pwr_dn` returns to 0.
- R11: After `rst`, the phase is auto zero, `rdy` is 0, `mag` is 0 and `sign` is 0.
- R12: `mag` changes only during deintegrate, so a result stays stable through integrator zero, auto zero and integrate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four times the system tick rate |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | 1 holds the sequencer idle in auto zero |
| cmp_in | input | 1 | Front-end comparator output |
| int_sel | input | 3 | Integration length select |
| xfer_done | input | 1 | Pulse from the serial block when all result bits have been sent |
| phase | output | 2 | Phase code to the front end |
| mag | output | MAG_W | Deintegrate count (magnitude) |
| sign | output | 1 | Polarity, 1 = positive |
| rdy | output | 1 | Result ready for transfer |

## Verification
The bench builds the block with MAG_W=6, INT_BASE=1, AZ_TICKS=3, IZ_TICKS=2 and XFER_TICKS=8. With these values every integrate length, including the longest at 180 ticks, takes only a few hundred clocks. A deintegrate that never sees a falling edge saturates the counter at 63 within 256 clocks. The transfer timeout expires after 32 clocks. The small values let the bench measure the exact length of every phase against R2 and R3, and push one cycle each through the counter ceiling, the zero-count result, a timeout, a select change in mid-integrate and a power-down in mid-deintegrate.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int MAG_W      = 23,
  parameter int INT_BASE   = 1536,
  parameter int AZ_TICKS   = 1843,
  parameter int IZ_TICKS   = 1843,
  parameter int XFER_TICKS = 5069
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_dn,
  input  logic             cmp_in,
  input  logic [2:0]       int_sel,
  input  logic             xfer_done,
  output logic [1:0]       phase,
  output logic [MAG_W-1:0] mag,
  output logic             sign,
  output logic             rdy
);

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LIM = maxi(maxi(INT_BASE * 180, AZ_TICKS), maxi(IZ_TICKS, XFER_TICKS));
  localparam int CW  = $clog2(LIM + 1);

  localparam logic [1:0] PH_AZ  = 2'b00;
  localparam logic [1:0] PH_INT = 2'b01;
  localparam logic [1:0] PH_DI  = 2'b10;
  localparam logic [1:0] PH_IZ  = 2'b11;

  localparam logic [MAG_W-1:0] MAG_MAX = '1;
  localparam logic [CW-1:0]    CNT_MAX = '1;
  localparam logic [CW-1:0]    AZ_LAST = CW'(AZ_TICKS - 1);
  localparam logic [CW-1:0]    IZ_LAST = CW'(IZ_TICKS - 1);
  localparam logic [CW-1:0]    TO_LAST = CW'(XFER_TICKS - 1);

  function automatic logic [CW-1:0] int_len(logic [2:0] s);
    int m;
    case (s)
      3'd0: m = 10;
      3'd1: m = 12;
      3'd2: m = 20;
      3'd3: m = 30;
      3'd4: m = 40;
      3'd5: m = 60;
      3'd6: m = 120;
      default: m = 180;
    endcase
    return CW'(INT_BASE * m);
  endfunction

  logic [1:0]    pre;
  logic [CW-1:0] cnt, len_q;
  logic          cmp_q, pending;
  logic          tick, az_done, zero_cross;

  assign tick       = (pre == 2'd3);
  assign az_done    = (cnt >= AZ_LAST);
  assign zero_cross = cmp_q && !cmp_in;
  assign rdy        = pending && (phase == PH_AZ);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      phase   <= PH_AZ;
      cnt     <= '0;
      len_q   <= '0;
      cmp_q   <= 1'b0;
      pending <= 1'b0;
      mag     <= '0;
      sign    <= 1'b0;
    end else if (pwr_dn) begin
      pre     <= '0;
      phase   <= PH_AZ;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      pre <= pre + 2'd1;
      if (xfer_done) pending <= 1'b0;
      if (tick) begin
        cmp_q <= cmp_in;
        case (phase)
          PH_AZ: begin
            if (az_done && !pending) begin
              phase <= PH_INT;
              cnt   <= '0;
              len_q <= int_len(int_sel);
            end else begin
              if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
              if (pending && cnt == TO_LAST) pending <= 1'b0;
            end
          end
          PH_INT: begin
            if (cnt == len_q - CW'(1)) begin
              phase <= PH_DI;
              cnt   <= '0;
              sign  <= cmp_in;
              mag   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          PH_DI: begin
            if (zero_cross || mag == MAG_MAX) phase <= PH_IZ;
            else mag <= mag + MAG_W'(1);
          end
          default: begin
            if (cnt == IZ_LAST) begin
              phase   <= PH_AZ;
              cnt     <= '0;
              pending <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        endcase
      end
    end
  end

  // R1: phase only steps forward by one
  a_r1_phase_order: assert property (@(posedge clk) disable iff (rst)
    !pwr_dn |=> (phase == $past(phase)) || (phase == 2'($past(phase) + 2'd1)));

  // R8: a pending result lives only in auto zero
  a_r8_pending_in_az: assert property (@(posedge clk) disable iff (rst)
    pending |-> phase == PH_AZ);

  // R8: integrate never follows a cycle with ready raised
  a_r8_no_int_while_rdy: assert property (@(posedge clk) disable iff (rst)
    rdy |=> phase != PH_INT);

  // R6: the deintegrate count never wraps
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DI && $past(phase) == PH_DI) |-> mag >= $past(mag));

  // R12: result held outside deintegrate
  a_r12_mag_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_DI && $past(phase) != PH_DI) |-> $stable(mag));

  // R10: power-down idles the sequencer
  a_r10_pd_idle: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_dn) |-> (phase == PH_AZ && !pending));

  // R7: returning from integrator zero raises a pending result
  a_r7_result_pending: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_IZ && phase == PH_AZ && !$past(pwr_dn)) |-> pending);

endmodule

// File: tb/dslope_seq_tb_top.sv
module dslope_seq_tb_top;
  localparam int MW  = 6;
  localparam int IB  = 1;
  localparam int AZT = 3;
  localparam int IZT = 2;
  localparam int XT  = 8;

  logic clk = 1'b0, rst = 1'b1, pwr_dn = 1'b0, cmp_in = 1'b1, xfer_done = 1'b0;
  logic [2:0] int_sel = 3'd5;
  logic [1:0] phase;
  logic [MW-1:0] mag;
  logic sign, rdy;

  dslope_seq #(.MAG_W(MW), .INT_BASE(IB), .AZ_TICKS(AZT), .IZ_TICKS(IZT), .XFER_TICKS(XT)) dut_i (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .cmp_in(cmp_in), .int_sel(int_sel),
    .xfer_done(xfer_done), .phase(phase), .mag(mag), .sign(sign), .rdy(rdy));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int q_ph[$], q_dur[$], q_mag[$], q_sgn[$];
  string q_tag[$];
  int cur_ph = -1, run = 0;
  logic rdy_prev = 1'b0;

  function automatic int mult(int s);
    case (s)
      0: return 10;  1: return 12;  2: return 20;  3: return 30;
      4: return 40;  5: return 60;  6: return 120; default: return 180;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_ph(int p, int d, string t);
    q_ph.push_back(p); q_dur.push_back(d); q_tag.push_back(t);
  endtask

  // monitor: phase durations and results
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cur_ph < 0) begin
          cur_ph = int'(phase); run = 1;
        end else if (int'(phase) != cur_ph) begin
          if (q_ph.size() > 0) begin
            int ep, ed; string et;
            ep = q_ph.pop_front(); ed = q_dur.pop_front(); et = q_tag.pop_front();
            chk(cur_ph == ep, "R1", "phase order", cur_ph, ep);
            if (ed > 0) begin
              chk(run == ed, et, "phase length in clocks", run, ed);
              chk(run % 4 == 0, "R2", "length multiple of 4", run % 4, 0);
            end
          end
          cur_ph = int'(phase); run = 1;
        end else begin
          run++;
        end
        if (rdy && !rdy_prev && q_mag.size() > 0) begin
          int em, es;
          em = q_mag.pop_front(); es = q_sgn.pop_front();
          chk(int'(mag) == em, "R5", "magnitude", int'(mag), em);
          chk(int'(sign) == es, "R4", "polarity", int'(sign), es);
        end
        rdy_prev = rdy;
      end
    end
  end

  task automatic run_cycle(int s, bit pol, int k, bit use_done, int s_mid);
    int len, em;
    len = mult(s) * IB;
    em = (k < 0) ? (2**MW - 1) : k;
    expect_ph(1, 4 * len, "R3");
    if (k < 0) expect_ph(2, 4 * (2**MW), "R6");
    else       expect_ph(2, 4 * (k + 1), "R5");
    expect_ph(3, 4 * IZT, "R7");
    q_mag.push_back(em); q_sgn.push_back(int'(pol));
    int_sel = 3'(s);
    cmp_in = pol;
    while (phase != 2'b01) @(negedge clk);
    if (s_mid >= 0) begin
      repeat (3) @(negedge clk);
      int_sel = 3'(s_mid);
    end
    while (phase != 2'b10) @(negedge clk);
    if (!pol) cmp_in = 1'b1;
    if (k >= 0) begin
      repeat (4 * k) @(negedge clk);
      cmp_in = 1'b0;
    end
    while (phase != 2'b00) @(negedge clk);
    chk(rdy == 1'b1, "R7", "ready on return to auto zero", int'(rdy), 1);
    if (use_done) begin
      expect_ph(0, 4 * AZT, "R8");
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
      chk(rdy == 1'b0, "R8", "ready cleared by done", int'(rdy), 0);
      chk(phase == 2'b00, "R8", "still in auto zero", int'(phase), 0);
    end else begin
      expect_ph(0, 4 * (XT + 1), "R9");
      repeat (4 * XT - 1) @(negedge clk);
      chk(rdy == 1'b1, "R9", "ready before timeout", int'(rdy), 1);
      @(negedge clk);
      chk(rdy == 1'b0, "R9", "ready after timeout", int'(rdy), 0);
      chk(phase == 2'b00, "R9", "auto zero at timeout", int'(phase), 0);
      chk(int'(mag) == em, "R12", "magnitude held in auto zero", int'(mag), em);
    end
  endtask

  task automatic pd_cycle();
    expect_ph(1, 4 * mult(2) * IB, "R3");
    expect_ph(2, 0, "R10");
    expect_ph(0, 0, "R10");
    int_sel = 3'd2;
    cmp_in = 1'b1;
    while (phase != 2'b10) @(negedge clk);
    repeat (3) @(negedge clk);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk(phase == 2'b00, "R10", "auto zero in power-down", int'(phase), 0);
    chk(rdy == 1'b0, "R10", "no ready in power-down", int'(rdy), 0);
    repeat (30) @(negedge clk);
    chk(phase == 2'b00, "R10", "idle held in power-down", int'(phase), 0);
    pwr_dn = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    expect_ph(0, 0, "R1");
    repeat (3) @(negedge clk);
    chk(phase == 2'b00, "R11", "reset phase", int'(phase), 0);
    chk(rdy == 1'b0, "R11", "reset ready", int'(rdy), 0);
    chk(mag == '0, "R11", "reset magnitude", int'(mag), 0);
    chk(sign == 1'b0, "R11", "reset polarity", int'(sign), 0);
    rst = 1'b0;
    run_cycle(5, 1'b1, 5, 1'b1, -1);
    run_cycle(0, 1'b0, 9, 1'b0, -1);
    run_cycle(7, 1'b1, -1, 1'b1, -1);
    run_cycle(1, 1'b1, 0, 1'b1, 7);
    pd_cycle();
    run_cycle(6, 1'b0, 3, 1'b1, -1);
    while (phase != 2'b01) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule